// File: doc/BRIEF.md
# Auto-Precharge Command Expander

This block sits on a stream of timestamped DRAM commands. Each command has a type code, a bank and an issue cycle. A read or write that carries an auto-precharge request leaves the block as a plain read or write. For that command the block also schedules a separate precharge to the same bank. The precharge time is never earlier than the bank's last activate plus the minimum row-active time.

Scheduled precharges wait in a small pool. Each one is released ahead of the first main command whose time reaches it. The pool is also released when it fills, or when a flush is requested. A flush ends with an end marker. If the first command of the stream is issued after cycle 1, a precharge-all at cycle 0 is placed before it to give the banks a known starting state. A plain precharge or precharge-all issued at cycle 0 is absorbed and not forwarded.

Top module: `apx_expander`

## Requirements
- R1: Each accepted activate (code 0) stores its issue cycle for its bank. Until a bank receives an activate, its stored cycle is 0.
- R2: An accepted read with auto-precharge (code 3) leaves as a read (code 1), and a write with auto-precharge (code 4) leaves as a write (code 2). Bank and time are unchanged. Codes 3 and 4 never appear at the output.
- R3: Each auto-precharge command schedules a precharge (code 5) to the same bank. Its time is the larger of two values: issue time plus the read offset (`ap_off_rd`) or the write offset (`ap_off_wr`), and that bank's stored activate cycle plus `t_ras`.
- R4: A main command may be presented while a pending precharge has a time equal to or earlier than the command's time. In that case the precharge is emitted first, and the command is held with `in_ready` low until no pending precharge is due.
- R5: The first command after reset may have a time greater than 1. In that case a precharge-all (code 6) with bank 0 and time 0 is emitted before it. This happens once.
- R6: A precharge (code 5) or precharge-all (code 6) with time 0 is accepted and produces no output.
- R7: While the pool is full, `in_ready` is low. The earliest pending precharge is emitted on each such cycle.
- R8: A `flush` pulse lowers `in_ready`. All pending precharges are then emitted one per cycle in ascending time order. After them comes an end marker (code 15) with bank 0 and the time of the last emitted command.
- R9: After reset, `out_valid` is low, the pool is empty, and `in_ready` is high.
- R10: Any other accepted command (activate, plain read or write, refresh code 7, and so on) is forwarded with code, bank and time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input command present |
| in_ready | output | 1 | Input command accepted at this edge |
| in_cmd | input | 4 | Input command code |
| in_bank | input | BW | Input bank |
| in_time | input | TW | Input issue cycle |
| flush | input | 1 | Request to drain the pool and emit an end marker |
| t_ras | input | OW | Minimum activate-to-precharge time |
| ap_off_rd | input | OW | Precharge offset after a read |
| ap_off_wr | input | OW | Precharge offset after a write |
| out_valid | output | 1 | Output command present for one cycle |
| out_cmd | output | 4 | Output command code |
| out_bank | output | BW | Output bank |
| out_time | output | TW | Output issue cycle |

## Verification
Every output is registered, so a result appears at the clock edge that accepts its command or releases its precharge, and it is visible for exactly one cycle. A held command therefore leaves one cycle after its inserted precharge or precharge-all. A flush takes one cycle to take effect, and then emits one pending precharge per cycle before the marker. The bench queues the expected results in emission order. It compares them on the falling edge after each output edge, and it flags any output that was not expected, which also covers the absorbed precharges.

// File: rtl/apx_pkg.sv
package apx_pkg;
  localparam logic [3:0] APX_ACT  = 4'd0;
  localparam logic [3:0] APX_RD   = 4'd1;
  localparam logic [3:0] APX_WR   = 4'd2;
  localparam logic [3:0] APX_RDA  = 4'd3;
  localparam logic [3:0] APX_WRA  = 4'd4;
  localparam logic [3:0] APX_PRE  = 4'd5;
  localparam logic [3:0] APX_PREA = 4'd6;
  localparam logic [3:0] APX_REF  = 4'd7;
  localparam logic [3:0] APX_END  = 4'd15;
endpackage

// File: rtl/apx_act_table.sv
module apx_act_table #(
  parameter int BANKS = 8,
  parameter int BW    = 3,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bank,
  input  logic [TW-1:0] wr_time,
  input  logic [BW-1:0] rd_bank,
  output logic [TW-1:0] rd_time
);
  logic [TW-1:0]    act_q [BANKS];
  logic [BANKS-1:0] bank_we;

  for (genvar g = 0; g < BANKS; g++) begin : g_we
    assign bank_we[g] = wr_en && (wr_bank == BW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BANKS; i++) act_q[i] <= '0;
    end else begin
      for (int i = 0; i < BANKS; i++)
        if (bank_we[i]) act_q[i] <= wr_time;
    end
  end

  assign rd_time = act_q[rd_bank];

  // R1
  one_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
endmodule

// File: rtl/apx_pend_pool.sv
module apx_pend_pool #(
  parameter int DEPTH = 4,
  parameter int BW    = 3,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_time,
  input  logic [BW-1:0] push_bank,
  input  logic          pop,
  output logic          head_valid,
  output logic [TW-1:0] head_time,
  output logic [BW-1:0] head_bank,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slot_v_q, slot_v_n;
  logic [TW-1:0]    slot_t_q [DEPTH];
  logic [BW-1:0]    slot_b_q [DEPTH];
  logic [IW-1:0]    head_idx, free_idx;
  logic             free_found;

  always_comb begin
    head_valid = 1'b0;
    head_idx   = '0;
    head_time  = '0;
    head_bank  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_v_q[i] && (!head_valid || slot_t_q[i] < head_time)) begin
        head_valid = 1'b1;
        head_idx   = IW'(i);
        head_time  = slot_t_q[i];
        head_bank  = slot_b_q[i];
      end
    end
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot_v_q[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign full = !free_found;

  always_comb begin
    slot_v_n = slot_v_q;
    if (pop && head_valid) slot_v_n[head_idx] = 1'b0;
    if (push && free_found) slot_v_n[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_t_q[i] <= '0;
        slot_b_q[i] <= '0;
      end
    end else begin
      slot_v_q <= slot_v_n;
      if (push && free_found) begin
        slot_t_q[free_idx] <= push_time;
        slot_b_q[free_idx] <= push_bank;
      end
    end
  end

  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  pop_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/apx_expander.sv
module apx_expander
  import apx_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int DEPTH = 4,
  parameter int TW    = 32,
  parameter int OW    = 8,
  parameter int BW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_cmd,
  input  logic [BW-1:0] in_bank,
  input  logic [TW-1:0] in_time,
  input  logic          flush,
  input  logic [OW-1:0] t_ras,
  input  logic [OW-1:0] ap_off_rd,
  input  logic [OW-1:0] ap_off_wr,
  output logic          out_valid,
  output logic [3:0]    out_cmd,
  output logic [BW-1:0] out_bank,
  output logic [TW-1:0] out_time
);
  logic          flushing_q, flushing_n;
  logic          init_q, init_n;
  logic [TW-1:0] last_q;
  logic          emit;
  logic [3:0]    e_cmd;
  logic [BW-1:0] e_bank;
  logic [TW-1:0] e_time;
  logic          act_we, push, pop;
  logic [TW-1:0] act_time, push_time, by_offset, by_floor;
  logic          head_valid, pool_full, need_prea, head_due;
  logic [TW-1:0] head_time;
  logic [BW-1:0] head_bank;

  apx_act_table #(.BANKS(BANKS), .BW(BW), .TW(TW)) u_acts (
    .clk(clk), .rst_n(rst_n), .wr_en(act_we), .wr_bank(in_bank),
    .wr_time(in_time), .rd_bank(in_bank), .rd_time(act_time)
  );

  apx_pend_pool #(.DEPTH(DEPTH), .BW(BW), .TW(TW)) u_pool (
    .clk(clk), .rst_n(rst_n), .push(push), .push_time(push_time),
    .push_bank(in_bank), .pop(pop), .head_valid(head_valid),
    .head_time(head_time), .head_bank(head_bank), .full(pool_full)
  );

  assign by_offset = in_time + TW'((in_cmd == APX_WRA) ? ap_off_wr : ap_off_rd);
  assign by_floor  = act_time + TW'(t_ras);
  assign push_time = (by_offset > by_floor) ? by_offset : by_floor;
  assign need_prea = !init_q && in_valid && (in_time > TW'(1));
  assign head_due  = head_valid && in_valid && (in_time >= head_time);

  always_comb begin
    flushing_n = flushing_q;
    init_n     = init_q;
    in_ready   = 1'b0;
    emit       = 1'b0;
    e_cmd      = in_cmd;
    e_bank     = in_bank;
    e_time     = in_time;
    act_we     = 1'b0;
    push       = 1'b0;
    pop        = 1'b0;
    if (flushing_q) begin
      emit = 1'b1;
      if (head_valid) begin
        pop    = 1'b1;
        e_cmd  = APX_PRE;
        e_bank = head_bank;
        e_time = head_time;
      end else begin
        e_cmd      = APX_END;
        e_bank     = '0;
        e_time     = last_q;
        flushing_n = 1'b0;
      end
    end else if (flush) begin
      flushing_n = 1'b1;
    end else if (pool_full || head_due) begin
      emit   = 1'b1;
      pop    = 1'b1;
      e_cmd  = APX_PRE;
      e_bank = head_bank;
      e_time = head_time;
    end else if (need_prea) begin
      emit   = 1'b1;
      init_n = 1'b1;
      e_cmd  = APX_PREA;
      e_bank = '0;
      e_time = '0;
    end else begin
      in_ready = 1'b1;
      if (in_valid) begin
        init_n = 1'b1;
        emit   = 1'b1;
        unique case (in_cmd)
          APX_ACT: act_we = 1'b1;
          APX_RDA: begin e_cmd = APX_RD; push = 1'b1; end
          APX_WRA: begin e_cmd = APX_WR; push = 1'b1; end
          APX_PRE, APX_PREA: emit = (in_time != '0);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flushing_q <= 1'b0;
      init_q     <= 1'b0;
      last_q     <= '0;
      out_valid  <= 1'b0;
      out_cmd    <= '0;
      out_bank   <= '0;
      out_time   <= '0;
    end else begin
      flushing_q <= flushing_n;
      init_q     <= init_n;
      out_valid  <= emit;
      if (emit) begin
        out_cmd  <= e_cmd;
        out_bank <= e_bank;
        out_time <= e_time;
        last_q   <= e_time;
      end
    end
  end

  // R2
  no_ap_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cmd != APX_RDA && out_cmd != APX_WRA));
  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> !in_ready);
  // R8
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushing_q |-> !in_ready);
  // R5
  prea_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd == APX_PREA && out_time == '0 && !$past(init_q))
      |-> init_q);
endmodule

// File: tb/apx_expander_bench.sv
module apx_expander_bench;
  logic        clk, rst_n, in_valid, in_ready, flush;
  logic [3:0]  in_cmd;
  logic [2:0]  in_bank;
  logic [31:0] in_time;
  logic [7:0]  t_ras, ap_off_rd, ap_off_wr;
  logic        out_valid;
  logic [3:0]  out_cmd;
  logic [2:0]  out_bank;
  logic [31:0] out_time;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0]  q_cmd[$];
  logic [2:0]  q_bank[$];
  logic [31:0] q_time[$];
  string       q_req[$];

  apx_expander u_apx_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_bank(in_bank), .in_time(in_time), .flush(flush),
    .t_ras(t_ras), .ap_off_rd(ap_off_rd), .ap_off_wr(ap_off_wr),
    .out_valid(out_valid), .out_cmd(out_cmd), .out_bank(out_bank),
    .out_time(out_time)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic expect_out(input logic [3:0] c, input logic [2:0] b,
                            input logic [31:0] t, input string req);
    q_cmd.push_back(c); q_bank.push_back(b);
    q_time.push_back(t); q_req.push_back(req);
  endtask

  task automatic send(input logic [3:0] c, input logic [2:0] b,
                      input logic [31:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_bank = b; in_time = t;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200 && q_cmd.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (q_cmd.size() == 0) begin
        n_bad++;
        $display("FAIL R6: unexpected output cmd=%0d bank=%0d time=%0d, expected none",
                 out_cmd, out_bank, out_time);
      end else begin
        if (out_cmd !== q_cmd[0] || out_bank !== q_bank[0] || out_time !== q_time[0]) begin
          n_bad++;
          $display("FAIL %s: got cmd=%0d bank=%0d time=%0d, expected cmd=%0d bank=%0d time=%0d",
                   q_req[0], out_cmd, out_bank, out_time, q_cmd[0], q_bank[0], q_time[0]);
        end
        void'(q_cmd.pop_front()); void'(q_bank.pop_front());
        void'(q_time.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0;
    in_cmd = '0; in_bank = '0; in_time = '0;
    t_ras = 8'd20; ap_off_rd = 8'd6; ap_off_wr = 8'd10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R9: out_valid=%0b expected 0", out_valid);
    end
    n_cmp++;
    if (in_ready !== 1'b1) begin
      n_bad++; $display("FAIL R9: in_ready=%0b expected 1", in_ready);
    end

    // R5 start marker, R10 passthrough, R1 record activate
    expect_out(4'd6, 3'd0, 32'd0, "R5");
    expect_out(4'd0, 3'd1, 32'd10, "R10");
    send(4'd0, 3'd1, 32'd10);
    // R2 read conversion; R3 floor 10+20=30 beats 12+6
    expect_out(4'd1, 3'd1, 32'd12, "R2");
    send(4'd3, 3'd1, 32'd12);
    expect_out(4'd0, 3'd2, 32'd14, "R10");
    send(4'd0, 3'd2, 32'd14);
    // R4 pending 30 released before write at 40; R3 floor via R1
    expect_out(4'd5, 3'd1, 32'd30, "R3");
    expect_out(4'd2, 3'd2, 32'd40, "R2");
    send(4'd4, 3'd2, 32'd40);
    // R4 equal time: pending 50 (40+10) ahead of read at 50
    expect_out(4'd5, 3'd2, 32'd50, "R4");
    expect_out(4'd1, 3'd3, 32'd50, "R4");
    send(4'd1, 3'd3, 32'd50);
    expect_out(4'd7, 3'd0, 32'd55, "R10");
    send(4'd7, 3'd0, 32'd55);
    // R6 precharge and precharge-all at time 0 absorbed
    send(4'd5, 3'd0, 32'd0);
    send(4'd6, 3'd0, 32'd0);
    // R3 offset dominates; separate read/write offsets
    expect_out(4'd1, 3'd4, 32'd60, "R2");
    send(4'd3, 3'd4, 32'd60);
    expect_out(4'd2, 3'd5, 32'd61, "R2");
    send(4'd4, 3'd5, 32'd61);
    expect_out(4'd1, 3'd6, 32'd62, "R2");
    send(4'd3, 3'd6, 32'd62);
    wait_drain();
    // R8 ascending drain 66, 68, 71 then end marker
    expect_out(4'd5, 3'd4, 32'd66, "R8");
    expect_out(4'd5, 3'd6, 32'd68, "R8");
    expect_out(4'd5, 3'd5, 32'd71, "R8");
    expect_out(4'd15, 3'd0, 32'd71, "R8");
    do_flush();
    wait_drain();

    // R7 fill the pool of four
    for (int k = 0; k < 4; k++) begin
      expect_out(4'd1, 3'(k), 32'(100 + k), "R7");
      send(4'd3, 3'(k), 32'(100 + k));
    end
    expect_out(4'd5, 3'd0, 32'd106, "R7");
    expect_out(4'd0, 3'd7, 32'd104, "R7");
    @(negedge clk);
    in_valid = 1'b1; in_cmd = 4'd0; in_bank = 3'd7; in_time = 32'd104;
    #1;
    n_cmp++;
    if (in_ready !== 1'b0) begin
      n_bad++; $display("FAIL R7: in_ready=%0b expected 0 while full", in_ready);
    end
    forever begin
      if (in_ready) break;
      @(negedge clk); #1;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
    wait_drain();
    expect_out(4'd5, 3'd1, 32'd107, "R8");
    expect_out(4'd5, 3'd2, 32'd108, "R8");
    expect_out(4'd5, 3'd3, 32'd109, "R8");
    expect_out(4'd15, 3'd0, 32'd109, "R8");
    do_flush();
    wait_drain();

    if (q_cmd.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: %0d outputs missing, expected 0", q_req[0], q_cmd.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule